// File: doc/BRIEF.md
# Interleaved Memory Bank Access Scheduler

This block sits between an instruction scheduler and an interleaved store built from several independent memory boxes. Load and store requests arrive one at a time. Each carries an effective address, a register id and, for a store, the data to write. Each request is held in a small, ordered set of rows. A row records which box the request uses as a read (load) or as a write (store), so it has the form of a source matrix and a destination matrix whose columns are boxes. A box-busy vector marks the boxes that still have an access in flight.

In every bus slot (one clock cycle) the rows are scanned from oldest to youngest. The oldest request whose box is idle, and which breaks no ordering rule against older rows on the same box, is dispatched. Its row is then removed and the younger rows close the gap. A younger request to an idle box can therefore overtake an older request that is stuck on a busy box, while requests to the same box keep their arrival order. A completion pulse per box frees that box. For a load, a register-done pulse with the register id follows that completion, so the instruction scheduler can release the register. Store data is copied into the row when the request is accepted, so the source register is free at once. A full flag tells the sender to hold its request.

Top module: `membox_sched`

## Requirements
- R1: The box of a request is the low log2(NUM_BOX) bits of its effective address (bits [1:0] with the default 4 boxes); the upper address bits do not affect the choice of box.
- R2: A request is accepted at a rising edge where req_valid is 1 and req_full is 0. It takes the first free row after the occupied ones and can be dispatched from the following cycle. With no stored request, disp_valid is 0.
- R3: req_full is 1 exactly when all ROWS rows are occupied. A request presented while req_full is 1 is dropped and never dispatched.
- R4: At most one request is dispatched per cycle, and it is the oldest eligible row. While disp_valid is 1, disp_store, disp_box, disp_addr, disp_reg and disp_data show that request. The row is removed at the next rising edge.
- R5: The busy bit of a box is set at the edge where a request to it is dispatched. It is cleared at the edge where box_done for that box is 1. A request to a busy box is not dispatched. box_done for an idle box has no effect.
- R6: A younger request to an idle box is dispatched ahead of an older request that is waiting on a busy box.
- R7: Requests to the same box, loads and stores alike, are dispatched in arrival order. A load never passes an older store to its box, and a store never passes an older load or store to its box.
- R8: disp_data for a store equals the req_data value sampled at acceptance, whatever req_data does afterwards.
- R9: One cycle after box_done clears a box whose in-flight access is a load, ld_done for that box is 1 for one cycle, and the box's slice of ld_done_reg (bits [b*REG_W +: REG_W]) holds the load's register id. A store completion gives no pulse.
- R10: After reset all rows are empty, req_full, disp_valid, box_busy and ld_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Effective address |
| req_reg | input | REG_W | Register to load or register whose value is stored |
| req_data | input | DATA_W | Store data |
| req_full | output | 1 | All rows occupied; request is refused |
| disp_valid | output | 1 | A request is dispatched this cycle |
| disp_store | output | 1 | Dispatched request is a store |
| disp_box | output | BOX_W | Box of the dispatched request |
| disp_addr | output | ADDR_W | Address of the dispatched request |
| disp_reg | output | REG_W | Register id of the dispatched request |
| disp_data | output | DATA_W | Buffered store data |
| box_done | input | NUM_BOX | Per-box access completion pulse |
| box_busy | output | NUM_BOX | Box-busy vector |
| ld_done | output | NUM_BOX | Per-box load register-write done pulse |
| ld_done_reg | output | NUM_BOX*REG_W | Register id per box for ld_done |

## Verification
The bench holds one box busy and queues a younger request to another box behind a blocked one, to show that overtaking happens. A scheduler that stalls on its oldest row would leave the younger request waiting instead. It fills every row with mixed loads and stores to a single busy box, offers one more request while full, and then releases the box slot by slot. The dispatch order must follow arrival order, and the extra request must never appear; a broken shift-up or a full flag that lets the request slip in would show up here. Further checks cover store data changing after acceptance, completions on idle boxes, and the register-done pulse being given for loads only, exactly one cycle after the completion.

// File: rtl/msched_pkg.sv
package msched_pkg;

  // Interleaving: the box is taken from the low address bits (nbox is a power of two).
  function automatic int unsigned box_index(input int unsigned addr, input int unsigned nbox);
    return addr & (nbox - 1);
  endfunction

  // One-hot column vector for a box number.
  function automatic int unsigned box_column(input int unsigned box);
    return 32'd1 << box;
  endfunction

endpackage

// File: rtl/msched_rowq.sv
module msched_rowq #(
  parameter int ROWS    = 4,
  parameter int NUM_BOX = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int REG_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic                             push_store,
  input  logic [NUM_BOX-1:0]               push_s,
  input  logic [NUM_BOX-1:0]               push_d,
  input  logic [ADDR_W-1:0]                push_addr,
  input  logic [REG_W-1:0]                 push_rid,
  input  logic [DATA_W-1:0]                push_data,
  input  logic                             pop,
  input  logic [IDX_W-1:0]                 pop_idx,
  output logic [ROWS-1:0]                  row_vld,
  output logic [ROWS-1:0][NUM_BOX-1:0]     row_s,
  output logic [ROWS-1:0][NUM_BOX-1:0]     row_d,
  output logic [ROWS-1:0]                  row_store,
  output logic [ROWS-1:0][ADDR_W-1:0]      row_addr,
  output logic [ROWS-1:0][REG_W-1:0]       row_rid,
  output logic [ROWS-1:0][DATA_W-1:0]      row_data,
  output logic                             q_full
);
  localparam int CNT_W = $clog2(ROWS + 1);

  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] fill_pos;

  logic [ROWS-1:0]              vld_n;
  logic [ROWS-1:0][NUM_BOX-1:0] s_n, d_n;
  logic [ROWS-1:0]              st_n;
  logic [ROWS-1:0][ADDR_W-1:0]  addr_n;
  logic [ROWS-1:0][REG_W-1:0]   rid_n;
  logic [ROWS-1:0][DATA_W-1:0]  data_n;

  assign occ      = CNT_W'($countones(row_vld));
  assign q_full   = (occ == CNT_W'(ROWS));
  assign fill_pos = occ - (pop ? CNT_W'(1) : CNT_W'(0));

  // Remove the dispatched row, close the gap, then append at the first free row.
  always_comb begin
    vld_n  = row_vld;
    s_n    = row_s;
    d_n    = row_d;
    st_n   = row_store;
    addr_n = row_addr;
    rid_n  = row_rid;
    data_n = row_data;
    for (int r = 0; r < ROWS; r++) begin
      if (pop && r >= int'(pop_idx)) begin
        if (r == ROWS - 1) begin
          vld_n[r] = 1'b0;
          s_n[r]   = '0;
          d_n[r]   = '0;
        end else begin
          vld_n[r]  = row_vld[r+1];
          s_n[r]    = row_s[r+1];
          d_n[r]    = row_d[r+1];
          st_n[r]   = row_store[r+1];
          addr_n[r] = row_addr[r+1];
          rid_n[r]  = row_rid[r+1];
          data_n[r] = row_data[r+1];
        end
      end
    end
    for (int r = 0; r < ROWS; r++) begin
      if (push && CNT_W'(r) == fill_pos) begin
        vld_n[r]  = 1'b1;
        s_n[r]    = push_s;
        d_n[r]    = push_d;
        st_n[r]   = push_store;
        addr_n[r] = push_addr;
        rid_n[r]  = push_rid;
        data_n[r] = push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_vld <= '0;
      row_s   <= '0;
      row_d   <= '0;
    end else begin
      row_vld <= vld_n;
      row_s   <= s_n;
      row_d   <= d_n;
    end
  end

  always_ff @(posedge clk) begin
    row_store <= st_n;
    row_addr  <= addr_n;
    row_rid   <= rid_n;
    row_data  <= data_n;
  end

  // R2: occupied rows stay packed at the top.
  assert_rows_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_vld & ROWS'(row_vld + 1'b1)) == '0));

  // R3: a full queue with nothing leaving takes nothing in.
  assert_refuse_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !pop) |=> $stable(row_vld));

endmodule

// File: rtl/msched_hazard.sv
module msched_hazard #(
  parameter int ROWS    = 4,
  parameter int NUM_BOX = 4,
  parameter int IDX_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ROWS-1:0]              row_vld,
  input  logic [ROWS-1:0][NUM_BOX-1:0] row_s,
  input  logic [ROWS-1:0][NUM_BOX-1:0] row_d,
  input  logic [NUM_BOX-1:0]           busy,
  output logic [ROWS-1:0]              elig,
  output logic                         pick_vld,
  output logic [IDX_W-1:0]             pick_idx
);
  logic [NUM_BOX-1:0] older_s, older_d;

  // Eligibility: idle box, a load has no older store on its box,
  // a store has no older access of any kind on its box.
  always_comb begin
    older_s = '0;
    older_d = '0;
    for (int i = 0; i < ROWS; i++) begin
      elig[i] = row_vld[i]
             && (((row_s[i] | row_d[i]) & busy) == '0)
             && ((row_s[i] & older_d) == '0)
             && ((row_d[i] & (older_s | older_d)) == '0);
      if (row_vld[i]) begin
        older_s = older_s | row_s[i];
        older_d = older_d | row_d[i];
      end
    end
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  function automatic logic older_on_box(input logic [IDX_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < ROWS; j++) begin
      if (j < int'(idx) && row_vld[j] &&
          (((row_s[j] | row_d[j]) & (row_s[idx] | row_d[idx])) != '0))
        hit = 1'b1;
    end
    return hit;
  endfunction

  // R7: the chosen row never has an older row waiting on the same box.
  assert_same_box_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> !older_on_box(pick_idx));

endmodule

// File: rtl/msched_busy.sv
module msched_busy #(
  parameter int NUM_BOX = 4,
  parameter int REG_W   = 3,
  parameter int BOX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     claim_vld,
  input  logic [BOX_W-1:0]         claim_box,
  input  logic                     claim_store,
  input  logic [REG_W-1:0]         claim_rid,
  input  logic [NUM_BOX-1:0]       box_done,
  output logic [NUM_BOX-1:0]       busy,
  output logic [NUM_BOX-1:0]       ld_done,
  output logic [NUM_BOX*REG_W-1:0] ld_done_reg
);
  logic [NUM_BOX-1:0]            box_claim;
  logic [NUM_BOX-1:0]            box_release;
  logic [NUM_BOX-1:0]            ld_pend;
  logic [NUM_BOX-1:0][REG_W-1:0] ld_rid;
  logic [NUM_BOX-1:0][REG_W-1:0] ld_done_rid;

  assign box_claim   = claim_vld ? NUM_BOX'(msched_pkg::box_column(32'(claim_box))) : '0;
  assign box_release = box_done & busy;
  assign ld_done_reg = ld_done_rid;

  for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[b]        <= 1'b0;
        ld_pend[b]     <= 1'b0;
        ld_rid[b]      <= '0;
        ld_done[b]     <= 1'b0;
        ld_done_rid[b] <= '0;
      end else begin
        ld_done[b] <= box_release[b] & ld_pend[b];
        if (box_release[b]) begin
          busy[b]        <= 1'b0;
          ld_done_rid[b] <= ld_rid[b];
        end
        if (box_claim[b]) begin
          busy[b]    <= 1'b1;
          ld_pend[b] <= !claim_store;
          ld_rid[b]  <= claim_rid;
        end
      end
    end

    // R9: a register-done pulse only follows the freeing of that box.
    assert_ld_done_after_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done[b] |-> $fell(busy[b]));

    // R5: a box is never claimed while still busy.
    assert_no_double_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
      box_claim[b] |-> !busy[b]);
  end

endmodule

// File: rtl/membox_sched.sv
module membox_sched #(
  parameter int NUM_BOX = 4,
  parameter int ROWS    = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int REG_W   = 3,
  localparam int BOX_W  = $clog2(NUM_BOX),
  localparam int IDX_W  = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_store,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [REG_W-1:0]         req_reg,
  input  logic [DATA_W-1:0]        req_data,
  output logic                     req_full,
  output logic                     disp_valid,
  output logic                     disp_store,
  output logic [BOX_W-1:0]         disp_box,
  output logic [ADDR_W-1:0]        disp_addr,
  output logic [REG_W-1:0]         disp_reg,
  output logic [DATA_W-1:0]        disp_data,
  input  logic [NUM_BOX-1:0]       box_done,
  output logic [NUM_BOX-1:0]       box_busy,
  output logic [NUM_BOX-1:0]       ld_done,
  output logic [NUM_BOX*REG_W-1:0] ld_done_reg
);
  logic                         accept;
  logic [BOX_W-1:0]             new_box;
  logic [NUM_BOX-1:0]           new_col;
  logic [ROWS-1:0]              row_vld;
  logic [ROWS-1:0][NUM_BOX-1:0] row_s, row_d;
  logic [ROWS-1:0]              row_store;
  logic [ROWS-1:0][ADDR_W-1:0]  row_addr;
  logic [ROWS-1:0][REG_W-1:0]   row_rid;
  logic [ROWS-1:0][DATA_W-1:0]  row_data;
  logic [ROWS-1:0]              elig;
  logic                         pick_vld;
  logic [IDX_W-1:0]             pick_idx;

  assign accept  = req_valid && !req_full;
  assign new_box = BOX_W'(msched_pkg::box_index(32'(req_addr), NUM_BOX));
  assign new_col = NUM_BOX'(msched_pkg::box_column(32'(new_box)));

  msched_rowq #(
    .ROWS(ROWS), .NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .REG_W(REG_W), .IDX_W(IDX_W)
  ) rowq_i (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_store(req_store),
    .push_s(req_store ? '0 : new_col),
    .push_d(req_store ? new_col : '0),
    .push_addr(req_addr), .push_rid(req_reg), .push_data(req_data),
    .pop(pick_vld), .pop_idx(pick_idx),
    .row_vld(row_vld), .row_s(row_s), .row_d(row_d), .row_store(row_store),
    .row_addr(row_addr), .row_rid(row_rid), .row_data(row_data),
    .q_full(req_full)
  );

  msched_hazard #(.ROWS(ROWS), .NUM_BOX(NUM_BOX), .IDX_W(IDX_W)) hazard_i (
    .clk(clk), .rst_n(rst_n),
    .row_vld(row_vld), .row_s(row_s), .row_d(row_d), .busy(box_busy),
    .elig(elig), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  assign disp_valid = pick_vld;
  assign disp_store = row_store[pick_idx];
  assign disp_addr  = row_addr[pick_idx];
  assign disp_reg   = row_rid[pick_idx];
  assign disp_data  = row_data[pick_idx];
  assign disp_box   = BOX_W'(msched_pkg::box_index(32'(row_addr[pick_idx]), NUM_BOX));

  msched_busy #(.NUM_BOX(NUM_BOX), .REG_W(REG_W), .BOX_W(BOX_W)) busy_i (
    .clk(clk), .rst_n(rst_n),
    .claim_vld(disp_valid), .claim_box(disp_box),
    .claim_store(disp_store), .claim_rid(disp_reg),
    .box_done(box_done), .busy(box_busy),
    .ld_done(ld_done), .ld_done_reg(ld_done_reg)
  );

  // R5: dispatch goes only to an idle box, and the box is busy afterwards.
  assert_dispatch_idle_box_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !box_busy[disp_box]);
  assert_box_marked_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> box_busy[$past(disp_box)]);

  // R4: a dispatch without an arrival leaves exactly one row fewer.
  assert_one_row_removed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !accept) |=> ($countones(row_vld) + 1 == $past($countones(row_vld))));

endmodule

// File: tb/membox_sched_tb_top.sv
module membox_sched_tb_top;
  localparam int NB = 4;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [RW-1:0] req_reg = '0;
  logic [7:0]    req_data = '0;
  logic          req_full, disp_valid, disp_store;
  logic [1:0]    disp_box;
  logic [7:0]    disp_addr, disp_data;
  logic [RW-1:0] disp_reg;
  logic [NB-1:0] box_done = '0;
  logic [NB-1:0] box_busy, ld_done;
  logic [NB*RW-1:0] ld_done_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  membox_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
    .req_reg(req_reg), .req_data(req_data), .req_full(req_full),
    .disp_valid(disp_valid), .disp_store(disp_store), .disp_box(disp_box),
    .disp_addr(disp_addr), .disp_reg(disp_reg), .disp_data(disp_data),
    .box_done(box_done), .box_busy(box_busy),
    .ld_done(ld_done), .ld_done_reg(ld_done_reg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int rid_of(input int b);
    return int'(ld_done_reg[b*RW +: RW]);
  endfunction

  // Present one request at a falling edge; return at the next falling edge.
  task automatic send(input bit st, input logic [7:0] a, input logic [RW-1:0] r, input logic [7:0] d);
    req_valid = 1'b1; req_store = st; req_addr = a; req_reg = r; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_done(input logic [NB-1:0] m);
    box_done = m;
    @(negedge clk);
    box_done = '0;
  endtask

  task automatic t_reset;
    chk(req_full == 1'b0, "R10 full", req_full, 0);
    chk(disp_valid == 1'b0, "R10 disp_valid", disp_valid, 0);
    chk(box_busy == '0, "R10 busy", box_busy, 0);
    chk(ld_done == '0, "R10 ld_done", ld_done, 0);
  endtask

  task automatic t_basic_load;
    send(1'b0, 8'h25, 3'd3, 8'h00);
    chk(disp_valid == 1'b1, "R2 dispatch after accept", disp_valid, 1);
    chk(disp_box == 2'd1, "R1 box from low bits", disp_box, 1);
    chk(disp_addr == 8'h25 && disp_reg == 3'd3 && disp_store == 1'b0, "R4 fields",
        {disp_addr, 1'b0, disp_reg}, {8'h25, 1'b0, 3'd3});
    @(negedge clk);
    chk(box_busy == 4'b0010, "R5 busy set", box_busy, 4'b0010);
    chk(disp_valid == 1'b0, "R2 empty no dispatch", disp_valid, 0);
    pulse_done(4'b0010);
    chk(box_busy == '0, "R5 busy cleared", box_busy, 0);
    chk(ld_done == 4'b0010 && rid_of(1) == 3, "R9 load done", {ld_done, 1'b0, ld_done_reg[5:3]}, {4'b0010, 1'b0, 3'd3});
    @(negedge clk);
    chk(ld_done == '0, "R9 single pulse", ld_done, 0);
  endtask

  task automatic t_store_buffer;
    req_valid = 1'b1; req_store = 1'b1; req_addr = 8'hAE; req_reg = 3'd5; req_data = 8'h91;
    @(negedge clk);
    req_valid = 1'b0; req_data = 8'h00;
    chk(disp_valid && disp_store && disp_box == 2'd2, "R1 store box", disp_box, 2);
    chk(disp_data == 8'h91, "R8 buffered data", disp_data, 8'h91);
    @(negedge clk);
    pulse_done(4'b0100);
    chk(box_busy == '0, "R5 store box freed", box_busy, 0);
    chk(ld_done == '0, "R9 no pulse for store", ld_done, 0);
    @(negedge clk);
    chk(ld_done == '0, "R9 no pulse for store later", ld_done, 0);
  endtask

  task automatic t_overtake;
    send(1'b0, 8'h04, 3'd1, 8'h00);
    chk(disp_valid && disp_box == 2'd0, "R4 first to box0", disp_box, 0);
    @(negedge clk);
    send(1'b0, 8'h08, 3'd2, 8'h00);
    chk(disp_valid == 1'b0, "R5 blocked on busy box", disp_valid, 0);
    send(1'b0, 8'h0B, 3'd4, 8'h00);
    chk(disp_valid && disp_reg == 3'd4 && disp_box == 2'd3, "R6 younger overtakes", disp_reg, 4);
    @(negedge clk);
    chk(box_busy == 4'b1001, "R5 two boxes busy", box_busy, 4'b1001);
    chk(disp_valid == 1'b0, "R5 still blocked", disp_valid, 0);
    pulse_done(4'b0001);
    chk(disp_valid && disp_reg == 3'd2, "R5 released request goes", disp_reg, 2);
    chk(ld_done == 4'b0001 && rid_of(0) == 1, "R9 box0 load done", rid_of(0), 1);
    pulse_done(4'b1000);
    chk(box_busy == 4'b0001, "R5 box0 reclaimed box3 freed", box_busy, 4'b0001);
    chk(ld_done == 4'b1000 && rid_of(3) == 4, "R9 box3 load done", rid_of(3), 4);
    pulse_done(4'b0001);
    chk(box_busy == '0, "R5 all idle", box_busy, 0);
    @(negedge clk);
  endtask

  task automatic t_full_and_order;
    int exp_r[4] = '{1, 2, 3, 4};
    bit exp_s[4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    send(1'b0, 8'h02, 3'd0, 8'h00);
    @(negedge clk);
    send(1'b1, 8'h06, 3'd1, 8'h11);
    send(1'b0, 8'h0A, 3'd2, 8'h00);
    send(1'b1, 8'h0E, 3'd3, 8'h33);
    send(1'b0, 8'h12, 3'd4, 8'h00);
    chk(req_full == 1'b1, "R3 full with all rows", req_full, 1);
    send(1'b0, 8'h16, 3'd7, 8'h00);
    chk(req_full == 1'b1, "R3 still full", req_full, 1);
    for (int k = 0; k < 4; k++) begin
      pulse_done(4'b0100);
      chk(disp_valid && disp_reg == 3'(exp_r[k]) && disp_store == exp_s[k],
          "R7 same-box arrival order", disp_reg, exp_r[k]);
      if (k == 0) chk(disp_data == 8'h11, "R8 store data held", disp_data, 8'h11);
      if (k == 1) chk(req_full == 1'b0, "R3 full drops", req_full, 0);
      @(negedge clk);
    end
    pulse_done(4'b0100);
    chk(disp_valid == 1'b0, "R3 refused request dropped", disp_valid, 0);
    chk(req_full == 1'b0 && box_busy == '0, "R3 empty at end", box_busy, 0);
    @(negedge clk);
  endtask

  task automatic t_idle_done;
    pulse_done(4'b1111);
    chk(box_busy == '0, "R5 idle completion ignored", box_busy, 0);
    chk(ld_done == '0, "R5 no pulse from idle box", ld_done, 0);
    @(negedge clk);
    chk(ld_done == '0 && disp_valid == 1'b0, "R5 idle completion quiet", ld_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic_load;
    t_store_buffer;
    t_overtake;
    t_full_and_order;
    t_idle_done;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule